// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers a wide set of level-sensitive interrupt request lines into one processor interrupt output. Software sees it through a small 32-bit register bus with a read strobe and a write strobe. Every source has a mask bit. Mask bits are grouped in banks of 32. Software never rewrites a whole mask word: it enables sources through a write-one-to-clear alias and disables them through a write-one-to-set alias.

When no interrupt is outstanding, the controller takes the lowest-numbered source that is both asserted and unmasked. It latches that number into an active-number register and raises the interrupt output. The choice stays frozen, whatever the sources and masks do, until software writes an acknowledge. The next choice is then made from the live state. A source that is still high is taken again.

The controller also provides a raw and a masked pending view per bank, and a small per-source configuration word that software can save and restore. It has a revision register, a plain configuration bit, and a timed soft reset with a completion flag.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After hardware reset every mask bit reads 1, the active-number register at 0x40 reads 0, irq_o is 0 and the reset-done flag (bit 0 at 0x14) reads 1.
- R2: Writing a word to 0x88 + 0x20·n clears, in bank n's mask (read at 0x84 + 0x20·n), each bit that is 1 in the word; mask bits written as 0 keep their value.
- R3: Writing a word to 0x8C + 0x20·n sets, in bank n's mask, each bit that is 1 in the word; mask bits written as 0 keep their value.
- R4: 0x80 + 0x20·n reads bank n's raw input levels, and 0x98 + 0x20·n reads the inputs that are high and unmasked (bit i of bank n is source 32·n + i).
- R5: While no interrupt is active, the lowest-numbered high and unmasked source is latched at the next clock edge; irq_o rises at that edge, and 0x40 returns its number in bits 6:0.
- R6: While an interrupt is active, its number and irq_o do not change, even if its source falls, a lower source rises or masks change.
- R7: Writing bit 0 = 1 at 0x48 drops irq_o at the next edge; a new choice follows one edge later, including the same source if it is still high; a write at 0x48 with bit 0 = 0 has no effect; an acknowledge and a newly rising source in the same cycle yield the acknowledge first.
- R8: Writing bit 1 = 1 at 0x10 starts a soft reset lasting 4 cycles. During it the reset-done flag reads 0 and bit 1 at 0x10 reads 1. Afterwards bit 1 reads 0, and all masks, configuration words, the configuration bit and the active state are back in their reset values.
- R9: Bit 0 at 0x10 is a plain read/write bit, reset to 0.
- R10: 0x00 returns the revision: major number in bits 7:4, minor number in bits 3:0 (defaults 2 and 1, reading 0x21).
- R11: Source i has a configuration word at 0x100 + 4·i that stores the low 8 bits written and reads 0 above them.
- R12: Read data appears on bus_rdata at the clock edge that samples bus_rd. The clear and set aliases and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Level-sensitive interrupt request lines |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two functions can land on the same clock edge: the acknowledge that frees the active slot, and the arrival of a new, lower-numbered unmasked source. The bench provokes this by raising source 2 in the very cycle it writes the acknowledge for source 9. It then judges the result at the ports: irq_o must read 0 one cycle later and 1 the cycle after, and the active-number register must then return 2. A second overlap, a source falling while it is the active one, is checked by reading that the latched number survives until the acknowledge.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;

   // fixed register offsets (byte addresses)
   localparam int unsigned OFF_REV    = 'h000;
   localparam int unsigned OFF_CFG    = 'h010;
   localparam int unsigned OFF_STAT   = 'h014;
   localparam int unsigned OFF_ACT    = 'h040;
   localparam int unsigned OFF_ACK    = 'h048;
   localparam int unsigned OFF_BANK0  = 'h080;
   localparam int unsigned BANK_STEP  = 'h020;
   localparam int unsigned OFF_LINE0  = 'h100;
   localparam int unsigned DATA_W     = 32;

   // register slots inside one bank window
   typedef enum logic [2:0] {
      BK_NONE,
      BK_RAW,
      BK_MASK,
      BK_CLR,
      BK_SET,
      BK_PEND
   } bank_sel_e;

   function automatic bank_sel_e bank_slot(input logic [4:0] sub);
      case (sub)
         5'h00:   return BK_RAW;
         5'h04:   return BK_MASK;
         5'h08:   return BK_CLR;
         5'h0C:   return BK_SET;
         5'h18:   return BK_PEND;
         default: return BK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_all,
   input  logic         wr_clr,
   input  logic         wr_set,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] src,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] pend_o
);

   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (clear_all) begin
         mask_q <= '1;
      end else if (wr_clr) begin
         mask_q <= mask_q & ~wdata;
      end else if (wr_set) begin
         mask_q <= mask_q | wdata;
      end
   end

   assign mask_o = mask_q;
   assign pend_o = src & ~mask_q;

   // clear alias: ones clear, zeros leave bits alone
   assert_clr_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !clear_all) |=>
         (((mask_o & $past(wdata)) == '0) &&
          ((mask_o & ~$past(wdata)) == ($past(mask_o) & ~$past(wdata)))));

   // set alias: ones set, zeros leave bits alone
   assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && !wr_clr && !clear_all) |=>
         (((mask_o & $past(wdata)) == $past(wdata)) &&
          ((mask_o & ~$past(wdata)) == ($past(mask_o) & ~$past(wdata)))));

endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
   parameter int N    = 96,
   parameter int ID_W = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   output logic            valid_o,
   output logic [ID_W-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx_o = ID_W'(i);
      end
   end

   assign valid_o = |req;

   // the winner is a real request and nothing below it is asking
   assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (req[idx_o] &&
                   ((req & ((N'(1) << idx_o) - N'(1))) == '0)));

endmodule

// File: rtl/irq_soft_rst.sv
`timescale 1ns/1ps
module irq_soft_rst #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy_o
);

   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("irq_soft_rst: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end else if (start) begin
         cnt_q <= CW'(CYCLES);
      end
   end

   assign busy_o = (cnt_q != '0);

   // a started reset runs down one step per cycle, a new start is ignored
   assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

   assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_o) |=> (cnt_q == CW'(CYCLES)));

endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC     = 96,
   parameter int BANK_W      = 32,
   parameter int CFG_W       = 8,
   parameter int SRST_CYCLES = 4,
   parameter int REV_MAJOR   = 2,
   parameter int REV_MINOR   = 1,
   parameter int ADDR_W      = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_rd,
   output logic [31:0]        bus_rdata,
   output logic               irq_o
);

   localparam int NBANK     = NUM_SRC / BANK_W;
   localparam int ID_W      = $clog2(NUM_SRC);
   localparam int BK_IDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int BANK_END  = OFF_BANK0 + NBANK * BANK_STEP;
   localparam int LINE_END  = OFF_LINE0 + 4 * NUM_SRC;

   localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(OFF_REV);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(OFF_ACT);
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);
   localparam logic [ADDR_W-1:0] A_BK_LO = ADDR_W'(OFF_BANK0);
   localparam logic [ADDR_W-1:0] A_BK_HI = ADDR_W'(BANK_END);
   localparam logic [ADDR_W-1:0] A_LN_LO = ADDR_W'(OFF_LINE0);
   localparam logic [ADDR_W-1:0] A_LN_HI = ADDR_W'(LINE_END);

   // elaboration-time parameter checks
   if (NUM_SRC % BANK_W != 0) begin : g_bad_banking
      $error("irq_vector_ctrl: NUM_SRC must be a multiple of BANK_W");
   end
   if (BANK_W > DATA_W) begin : g_bad_bank_w
      $error("irq_vector_ctrl: BANK_W must fit the data bus");
   end
   if (BANK_END > OFF_LINE0) begin : g_bad_nbank
      $error("irq_vector_ctrl: bank windows overlap the line words");
   end
   if (LINE_END > (1 << ADDR_W) || ADDR_W < ID_W + 2) begin : g_bad_addr
      $error("irq_vector_ctrl: ADDR_W too small for the line words");
   end
   if (ID_W > 7 || CFG_W > DATA_W || CFG_W < 1) begin : g_bad_widths
      $error("irq_vector_ctrl: source count or CFG_W out of range");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("irq_vector_ctrl: revision fields are 4 bits each");
   end

   // ---------------------------------------------------------------
   // address decode
   // ---------------------------------------------------------------
   logic [ADDR_W-1:0]   bk_off;
   logic [ADDR_W-1:0]   ln_off;
   logic [BK_IDX_W-1:0] bk_idx;
   logic [ID_W-1:0]     line_idx;
   logic                in_bank;
   logic                in_line;
   bank_sel_e           bk_sel;

   assign bk_off   = bus_addr - A_BK_LO;
   assign ln_off   = bus_addr - A_LN_LO;
   assign bk_idx   = bk_off[5 +: BK_IDX_W];
   assign line_idx = ln_off[2 +: ID_W];
   assign in_bank  = (bus_addr >= A_BK_LO) && (bus_addr < A_BK_HI);
   assign in_line  = (bus_addr >= A_LN_LO) && (bus_addr < A_LN_HI) &&
                     (bus_addr[1:0] == 2'b00);
   assign bk_sel   = in_bank ? bank_slot(bk_off[4:0]) : BK_NONE;

   // ---------------------------------------------------------------
   // soft reset sequencer
   // ---------------------------------------------------------------
   logic srst_busy;
   logic wr_ok;
   logic srst_go;
   logic ack_fire;

   assign wr_ok    = bus_wr && !srst_busy;
   assign srst_go  = wr_ok && (bus_addr == A_CFG) && bus_wdata[1];
   assign ack_fire = wr_ok && (bus_addr == A_ACK) && bus_wdata[0];

   irq_soft_rst #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (srst_go),
      .busy_o (srst_busy)
   );

   // ---------------------------------------------------------------
   // mask banks
   // ---------------------------------------------------------------
   logic [NUM_SRC-1:0] mask_all;
   logic [NUM_SRC-1:0] pend_all;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit = wr_ok && (bk_idx == BK_IDX_W'(b));

      irq_mask_bank #(.W(BANK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear_all (srst_busy),
         .wr_clr    (hit && (bk_sel == BK_CLR)),
         .wr_set    (hit && (bk_sel == BK_SET)),
         .wdata     (bus_wdata[BANK_W-1:0]),
         .src       (src_i[b*BANK_W +: BANK_W]),
         .mask_o    (mask_all[b*BANK_W +: BANK_W]),
         .pend_o    (pend_all[b*BANK_W +: BANK_W])
      );
   end

   // ---------------------------------------------------------------
   // selection and active slot
   // ---------------------------------------------------------------
   logic            pick_v;
   logic [ID_W-1:0] pick_n;
   logic            act_vld_q;
   logic [ID_W-1:0] act_num_q;

   irq_prio_pick #(.N(NUM_SRC), .ID_W(ID_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (pend_all),
      .valid_o (pick_v),
      .idx_o   (pick_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_vld_q <= 1'b0;
         act_num_q <= '0;
      end else if (srst_busy || ack_fire) begin
         act_vld_q <= 1'b0;
         act_num_q <= '0;
      end else if (!act_vld_q && pick_v) begin
         act_vld_q <= 1'b1;
         act_num_q <= pick_n;
      end
   end

   assign irq_o = act_vld_q;

   // ---------------------------------------------------------------
   // configuration bit and per-line words
   // ---------------------------------------------------------------
   logic             cfg_b0_q;
   logic [CFG_W-1:0] line_cfg_q [NUM_SRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_b0_q <= 1'b0;
      end else if (srst_busy) begin
         cfg_b0_q <= 1'b0;
      end else if (wr_ok && (bus_addr == A_CFG)) begin
         cfg_b0_q <= bus_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) line_cfg_q[i] <= '0;
      end else if (srst_busy) begin
         for (int i = 0; i < NUM_SRC; i++) line_cfg_q[i] <= '0;
      end else if (wr_ok && in_line) begin
         line_cfg_q[line_idx] <= bus_wdata[CFG_W-1:0];
      end
   end

   // ---------------------------------------------------------------
   // read path
   // ---------------------------------------------------------------
   logic [31:0]       rd_val;
   logic [BANK_W-1:0] bk_raw;
   logic [BANK_W-1:0] bk_mask;
   logic [BANK_W-1:0] bk_pend;

   assign bk_raw  = src_i[int'(bk_idx) * BANK_W +: BANK_W];
   assign bk_mask = mask_all[int'(bk_idx) * BANK_W +: BANK_W];
   assign bk_pend = pend_all[int'(bk_idx) * BANK_W +: BANK_W];

   always_comb begin
      rd_val = '0;
      if (bus_addr == A_REV) begin
         rd_val = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
      end else if (bus_addr == A_CFG) begin
         rd_val = {30'd0, srst_busy, cfg_b0_q};
      end else if (bus_addr == A_STAT) begin
         rd_val = {31'd0, !srst_busy};
      end else if (bus_addr == A_ACT) begin
         rd_val = 32'(act_num_q);
      end else if (in_line) begin
         rd_val = 32'(line_cfg_q[line_idx]);
      end else begin
         case (bk_sel)
            BK_RAW:  rd_val = 32'(bk_raw);
            BK_MASK: rd_val = 32'(bk_mask);
            BK_PEND: rd_val = 32'(bk_pend);
            default: rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_val;
      end
   end

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   assert_take_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && pick_v && !srst_busy && !ack_fire) |=>
         (irq_o && act_num_q == $past(pick_n)));

   assert_hold_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_fire && !srst_busy) |=>
         (irq_o && $stable(act_num_q)));

   assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> (!irq_o && act_num_q == '0));

   assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> (!irq_o && mask_all == '1 && !cfg_b0_q));

   assert_idle_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (act_num_q == '0));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

   typedef enum logic [1:0] {OP_WR, OP_RD, OP_SRC, OP_IRQ} op_e;

   typedef struct packed {
      op_e         op;
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 59;

   // OP_SRC: a = bank index, d = the 32 lines of that bank
   localparam vec_t VEC [NV] = '{
      '{OP_RD,  12'h000, 32'h0000_0021, 4'd10}, // R10 revision 2.1
      '{OP_RD,  12'h014, 32'h0000_0001, 4'd1 }, // R1 reset done
      '{OP_RD,  12'h084, 32'hFFFF_FFFF, 4'd1 }, // R1 bank0 masked
      '{OP_RD,  12'h0A4, 32'hFFFF_FFFF, 4'd1 }, // R1 bank1 masked
      '{OP_RD,  12'h0C4, 32'hFFFF_FFFF, 4'd1 }, // R1 bank2 masked
      '{OP_RD,  12'h040, 32'h0000_0000, 4'd1 }, // R1 no active
      '{OP_IRQ, 12'h000, 32'h0000_0000, 4'd1 }, // R1 irq low
      '{OP_RD,  12'h010, 32'h0000_0000, 4'd9 }, // R9 reset value
      '{OP_WR,  12'h010, 32'h0000_0001, 4'd9 },
      '{OP_RD,  12'h010, 32'h0000_0001, 4'd9 }, // R9 set
      '{OP_WR,  12'h010, 32'h0000_0000, 4'd9 },
      '{OP_RD,  12'h010, 32'h0000_0000, 4'd9 }, // R9 cleared
      '{OP_SRC, 12'h000, 32'h0000_0030, 4'd4 }, // lines 4 and 5 high
      '{OP_RD,  12'h080, 32'h0000_0030, 4'd4 }, // R4 raw view
      '{OP_RD,  12'h098, 32'h0000_0000, 4'd4 }, // R4 masked view
      '{OP_IRQ, 12'h000, 32'h0000_0000, 4'd5 }, // R5 masked, no irq
      '{OP_WR,  12'h088, 32'h0000_0020, 4'd2 }, // enable 5
      '{OP_RD,  12'h084, 32'hFFFF_FFDF, 4'd2 }, // R2
      '{OP_RD,  12'h098, 32'h0000_0020, 4'd4 }, // R4
      '{OP_IRQ, 12'h000, 32'h0000_0001, 4'd5 }, // R5 irq raised
      '{OP_RD,  12'h040, 32'h0000_0005, 4'd5 }, // R5 number 5
      '{OP_WR,  12'h088, 32'h0000_0010, 4'd2 }, // enable 4 (lower)
      '{OP_RD,  12'h084, 32'hFFFF_FFCF, 4'd2 }, // R2 other bits kept
      '{OP_RD,  12'h040, 32'h0000_0005, 4'd6 }, // R6 frozen on 5
      '{OP_WR,  12'h048, 32'h0000_0000, 4'd7 }, // not an ack
      '{OP_IRQ, 12'h000, 32'h0000_0001, 4'd7 }, // R7 still raised
      '{OP_RD,  12'h040, 32'h0000_0005, 4'd7 }, // R7 still 5
      '{OP_WR,  12'h048, 32'h0000_0001, 4'd7 }, // ack
      '{OP_RD,  12'h040, 32'h0000_0004, 4'd7 }, // R7 lower wins now
      '{OP_WR,  12'h08C, 32'h0000_0010, 4'd3 }, // disable 4
      '{OP_RD,  12'h084, 32'hFFFF_FFDF, 4'd3 }, // R3
      '{OP_RD,  12'h040, 32'h0000_0004, 4'd6 }, // R6 held though masked
      '{OP_WR,  12'h08C, 32'h0000_0000, 4'd3 }, // zeros: no change
      '{OP_RD,  12'h084, 32'hFFFF_FFDF, 4'd3 }, // R3
      '{OP_WR,  12'h048, 32'h0000_0001, 4'd7 },
      '{OP_RD,  12'h040, 32'h0000_0005, 4'd7 }, // R7 next choice 5
      '{OP_SRC, 12'h002, 32'h8000_0000, 4'd4 }, // line 95 high
      '{OP_WR,  12'h0C8, 32'h8000_0000, 4'd2 }, // enable 95
      '{OP_RD,  12'h0C4, 32'h7FFF_FFFF, 4'd2 }, // R2 bank2
      '{OP_RD,  12'h0D8, 32'h8000_0000, 4'd4 }, // R4 bank2 masked view
      '{OP_RD,  12'h0C0, 32'h8000_0000, 4'd4 }, // R4 bank2 raw view
      '{OP_SRC, 12'h000, 32'h0000_0000, 4'd6 }, // active line 5 falls
      '{OP_RD,  12'h040, 32'h0000_0005, 4'd6 }, // R6 still 5
      '{OP_WR,  12'h048, 32'h0000_0001, 4'd7 },
      '{OP_RD,  12'h040, 32'h0000_005F, 4'd5 }, // R5 line 95
      '{OP_WR,  12'h048, 32'h0000_0001, 4'd7 },
      '{OP_RD,  12'h040, 32'h0000_005F, 4'd7 }, // R7 level re-taken
      '{OP_SRC, 12'h002, 32'h0000_0000, 4'd7 },
      '{OP_WR,  12'h048, 32'h0000_0001, 4'd7 },
      '{OP_IRQ, 12'h000, 32'h0000_0000, 4'd7 }, // R7 nothing left
      '{OP_RD,  12'h040, 32'h0000_0000, 4'd7 }, // R7
      '{OP_WR,  12'h27C, 32'h0000_00A5, 4'd11},
      '{OP_RD,  12'h27C, 32'h0000_00A5, 4'd11}, // R11 last line
      '{OP_WR,  12'h104, 32'hFFFF_FF3C, 4'd11},
      '{OP_RD,  12'h104, 32'h0000_003C, 4'd11}, // R11 upper bits zero
      '{OP_RD,  12'h100, 32'h0000_0000, 4'd11}, // R11 neighbour untouched
      '{OP_RD,  12'h070, 32'h0000_0000, 4'd12}, // R12 unmapped
      '{OP_RD,  12'h088, 32'h0000_0000, 4'd12}, // R12 clear alias
      '{OP_RD,  12'h02C, 32'h0000_0000, 4'd12}  // R12 unmapped
   };

   logic         clk;
   logic         rst_n;
   logic [95:0]  src;
   logic [11:0]  addr;
   logic         wr;
   logic [31:0]  wdata;
   logic         rd;
   logic [31:0]  rdata;
   logic         irq;

   int checks;
   int errors;

   irq_vector_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rd    (rd),
      .bus_rdata (rdata),
      .irq_o     (irq)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr    = 1'b1;
      @(negedge clk);
      wr    = 1'b0;
   endtask

   // R12: the value is registered at the edge that samples the strobe
   task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      rd   = 1'b1;
      @(negedge clk);
      rd   = 1'b0;
      d    = rdata;
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
   end

   initial begin
      logic [31:0] got;
      checks = 0;
      errors = 0;
      rst_n  = 1'b0;
      src    = '0;
      addr   = '0;
      wr     = 1'b0;
      wdata  = '0;
      rd     = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int k = 0; k < NV; k++) begin
         case (VEC[k].op)
            OP_WR:  do_wr(VEC[k].a, VEC[k].d);
            OP_RD: begin
               do_rd(VEC[k].a, got);
               chk(int'(VEC[k].req), got, VEC[k].d);
            end
            OP_SRC: begin
               @(negedge clk);
               src[int'(VEC[k].a) * 32 +: 32] = VEC[k].d;
            end
            default: begin
               @(negedge clk);
               chk(int'(VEC[k].req), {31'd0, irq}, VEC[k].d);
            end
         endcase
      end

      // R7: acknowledge and a new lower source in the same cycle
      do_wr(12'h088, 32'h0000_0204);   // enable lines 2 and 9
      @(negedge clk);
      src[31:0] = 32'h0000_0200;
      do_rd(12'h040, got);
      chk(5, got, 32'd9);              // R5 line 9 taken
      @(negedge clk);
      src[31:0] = 32'h0000_0204;
      addr  = 12'h048;
      wdata = 32'h1;
      wr    = 1'b1;
      @(negedge clk);
      wr    = 1'b0;
      chk(7, {31'd0, irq}, 32'd0);     // R7 ack first
      @(negedge clk);
      chk(7, {31'd0, irq}, 32'd1);     // R7 choice one edge later
      do_rd(12'h040, got);
      chk(7, got, 32'd2);              // R7 lower line 2

      // R8: soft reset
      @(negedge clk);
      src[63:32] = 32'h0000_0001;
      do_wr(12'h0A8, 32'h0000_0001);
      do_wr(12'h27C, 32'h0000_0011);
      do_wr(12'h010, 32'h0000_0003);
      addr = 12'h014;
      rd   = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(8, rdata, (k < 4) ? 32'd0 : 32'd1);   // R8 busy window
      end
      rd = 1'b0;
      do_wr(12'h010, 32'h0000_0002);   // bit 1 shows while busy
      addr = 12'h010;
      rd   = 1'b1;
      @(negedge clk);
      rd   = 1'b0;
      chk(8, rdata, 32'h2);            // R8 bit 1 reads 1 mid reset
      repeat (4) @(negedge clk);
      do_rd(12'h010, got);
      chk(8, got, 32'h0);              // R8 self-cleared, bit 0 reset
      do_rd(12'h0A4, got);
      chk(8, got, 32'hFFFF_FFFF);      // R8 masks restored
      do_rd(12'h084, got);
      chk(8, got, 32'hFFFF_FFFF);      // R8
      do_rd(12'h040, got);
      chk(8, got, 32'h0);              // R8 no active
      @(negedge clk);
      chk(8, {31'd0, irq}, 32'd0);     // R8 line 32 high but masked
      do_rd(12'h27C, got);
      chk(8, got, 32'h0);              // R8 line word cleared
      do_rd(12'h014, got);
      chk(8, got, 32'h1);              // R8 done flag

      summary();
   end

endmodule